// File: doc/BRIEF.md
# Instruction Immediate Builder

This block is a purely combinational decode helper for a 32-bit base-integer instruction word. It looks at the 7-bit major opcode, picks which immediate layout that opcode carries, and builds the operand at the machine word width set by the `XLEN` parameter (32 or 64). Because the layout choice depends only on the opcode field, the unit can run alongside register-field and control decode in the same stage.

Each result bit is a small AND-OR selection over two or three fixed instruction bits or constant zero. Branch and jump offsets are produced by wiring the scattered encoded bits straight to their final positions, so there is no shift-by-one stage. Instruction bit 31 is the sign source for every sign-extended layout, and when `XLEN` is 64 the upper half of the result is that one bit fanned out.

Top module: `immgen_top`

## Requirements
- R1: The layout is picked from instruction bits 6:0: 0000011, 0010011 and 1100111 select the 12-bit load/ALU layout; 0100011 selects the store layout; 1100011 the branch layout; 0110111 and 0010111 the upper layout; 1101111 the jump layout; 1110011 with instruction bit 14 set selects the control-register layout.
- R2: The load/ALU layout yields instruction bits 31:20 sign-extended to `XLEN` bits.
- R3: The store layout yields {instruction bits 31:25, instruction bits 11:7} sign-extended to `XLEN` bits.
- R4: The branch layout yields {bit 31, bit 7, bits 30:25, bits 11:8, 0} as a signed 13-bit value; result bit 0 is always zero and the range is -4096 to +4094.
- R5: The upper layout places instruction bits 31:12 in result bits 31:12 with result bits 11:0 zero (sign-extended above bit 31 when `XLEN` is 64).
- R6: The jump layout yields {bit 31, bits 19:12, bit 20, bits 30:21, 0} as a signed 21-bit value; result bit 0 is always zero.
- R7: The control-register layout yields instruction bits 19:15 zero-extended; every result bit above bit 4 is zero even when instruction bit 31 is set.
- R8: Opcode 0110011, opcode 1110011 with instruction bit 14 clear, and any opcode not listed in R1 give an all-zero result.
- R9: For every sign-extended layout, the result's most significant bit equals instruction bit 31, and with `XLEN` 64 result bits 63:32 all copy instruction bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instrWord | input | 32 | Instruction word to decode |
| immValue | output | XLEN | Immediate operand, sign- or zero-extended as the layout requires |

## Verification
The bench aims at the bit positions where layouts reuse or swap sources: bit 11 of branches taken from instruction bit 7, bit 11 of jumps taken from bit 20, and bit 0 forced to zero for both; a design that shifted or mis-wired these would land offsets one bit off or pick up a stray odd bit. It drives the branch range extremes (+4094 and -4096), a jump with only the sign bit set, and an all-ones upper immediate, where a wrong extension shows up as a broken upper half at 64 bits. A control-register word with bit 31 set catches a design that sign-extends the 5-bit field, and a system word with bit 14 clear or a register-register word full of ones catches one that leaks instruction bits when no immediate exists. Random words for each opcode class are compared at both widths against a bench reference.

// File: rtl/immgen_pkg.sv
package immgen_pkg;

  localparam int INSTR_W = 32;
  localparam int OPC_W   = 7;

  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_ALUIMM = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_JREG   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_UPPER  = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_PCUP   = 7'b0010111;
  localparam logic [OPC_W-1:0] OPC_JUMP   = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_SYS    = 7'b1110011;

  // Layout select strobes from control to datapath; at most one sel* is high.
  typedef struct packed {
    logic selI;
    logic selS;
    logic selB;
    logic selU;
    logic selJ;
    logic selZ;
    logic signEn;
  } immStrobe_t;

endpackage

// File: rtl/immgen_ctrl.sv
module immgen_ctrl
  import immgen_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic             funct3Hi,
  output immStrobe_t       strobes
);

  always_comb begin
    strobes = '0;
    unique case (opcode)
      OPC_LOAD, OPC_ALUIMM, OPC_JREG: strobes.selI = 1'b1;
      OPC_STORE:                      strobes.selS = 1'b1;
      OPC_BRANCH:                     strobes.selB = 1'b1;
      OPC_UPPER, OPC_PCUP:            strobes.selU = 1'b1;
      OPC_JUMP:                       strobes.selJ = 1'b1;
      OPC_SYS:                        strobes.selZ = funct3Hi;
      default:                        strobes = '0;
    endcase
    strobes.signEn = strobes.selI | strobes.selS | strobes.selB |
                     strobes.selU | strobes.selJ;
  end

endmodule

// File: rtl/immgen_dpath.sv
module immgen_dpath
  import immgen_pkg::*;
#(
  parameter int XLEN = 64
)(
  input  logic [INSTR_W-1:7] instrHi,
  input  immStrobe_t         strobes,
  output logic [XLEN-1:0]    immOut
);

  logic        signBit;
  logic        midSign;
  logic [31:0] lowWord;

  // Single source for the sign; only gated, never multiplexed.
  assign signBit = instrHi[31] & strobes.signEn;
  assign midSign = instrHi[31] & (strobes.selI | strobes.selS | strobes.selB);

  always_comb begin
    lowWord[0] = (strobes.selI & instrHi[20]) |
                 (strobes.selS & instrHi[7])  |
                 (strobes.selZ & instrHi[15]);
    lowWord[4:1] = ({4{strobes.selI | strobes.selJ}} & instrHi[24:21]) |
                   ({4{strobes.selS | strobes.selB}} & instrHi[11:8])  |
                   ({4{strobes.selZ}}                & instrHi[19:16]);
    lowWord[10:5] = {6{strobes.selI | strobes.selS | strobes.selB | strobes.selJ}}
                    & instrHi[30:25];
    lowWord[11] = ((strobes.selI | strobes.selS) & instrHi[31]) |
                  (strobes.selB & instrHi[7]) |
                  (strobes.selJ & instrHi[20]);
    lowWord[19:12] = {8{midSign}} |
                     ({8{strobes.selU | strobes.selJ}} & instrHi[19:12]);
    lowWord[30:20] = {11{midSign | (strobes.selJ & instrHi[31])}} |
                     ({11{strobes.selU}} & instrHi[30:20]);
    lowWord[31] = signBit;
  end

  generate
    if (XLEN > 32) begin : g_wide
      localparam int UPPER_W = XLEN - 32;
      assign immOut = {{UPPER_W{signBit}}, lowWord};
    end else begin : g_narrow
      assign immOut = lowWord;
    end
  endgenerate

endmodule

// File: rtl/immgen_top.sv
module immgen_top
  import immgen_pkg::*;
#(
  parameter int XLEN = 64
)(
  input  logic [31:0]     instrWord,
  output logic [XLEN-1:0] immValue
);

  immStrobe_t strobes;

  immgen_ctrl u_ctrl (
    .opcode   (instrWord[OPC_W-1:0]),
    .funct3Hi (instrWord[14]),
    .strobes  (strobes)
  );

  immgen_dpath #(.XLEN(XLEN)) u_dpath (
    .instrHi (instrWord[INSTR_W-1:7]),
    .strobes (strobes),
    .immOut  (immValue)
  );

endmodule

// File: rtl/immgen_chk.sv
module immgen_chk
  import immgen_pkg::*;
#(
  parameter int XLEN = 64
)(
  input logic [OPC_W-1:0] opcode,
  input logic             funct3Hi,
  input logic             signIn,
  input logic [XLEN-1:0]  immValue
);

  logic isB, isJ, isU, isZ, isNone, isSigned;

  always_comb begin
    isB = (opcode == OPC_BRANCH);
    isJ = (opcode == OPC_JUMP);
    isU = (opcode == OPC_UPPER) || (opcode == OPC_PCUP);
    isZ = (opcode == OPC_SYS) && funct3Hi;
    isNone = (opcode == 7'b0110011) || ((opcode == OPC_SYS) && !funct3Hi);
    isSigned = isB || isJ || isU || (opcode == OPC_STORE) ||
               (opcode == OPC_LOAD) || (opcode == OPC_ALUIMM) || (opcode == OPC_JREG);
  end

  always_comb begin
    if (isB) begin
      assert_branch_even_R4: assert (immValue[0] == 1'b0);
    end
    if (isU) begin
      assert_upper_lowzero_R5: assert (immValue[11:0] == 12'd0);
    end
    if (isJ) begin
      assert_jump_even_R6: assert (immValue[0] == 1'b0);
    end
    if (isZ) begin
      assert_csr_zeroext_R7: assert (immValue[XLEN-1:5] == '0);
    end
    if (isNone) begin
      assert_noimm_zero_R8: assert (immValue == '0);
    end
    if (isSigned) begin
      assert_sign_source_R9: assert (immValue[XLEN-1] == signIn);
    end
  end

endmodule

bind immgen_top immgen_chk #(.XLEN(XLEN)) u_chk (
  .opcode   (instrWord[6:0]),
  .funct3Hi (instrWord[14]),
  .signIn   (instrWord[31]),
  .immValue (immValue)
);

// File: tb/immgen_top_bench.sv
module immgen_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instrWord = 32'd0;
  logic [63:0] imm64;
  logic [31:0] imm32;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;   // 4 ns period

  immgen_top #(.XLEN(64)) u_immgen_top (
    .instrWord (instrWord),
    .immValue  (imm64)
  );

  immgen_top #(.XLEN(32)) u_immgen_top_narrow (
    .instrWord (instrWord),
    .immValue  (imm32)
  );

  function automatic logic [63:0] refImm(input logic [31:0] w);
    case (w[6:0])
      7'b0000011, 7'b0010011, 7'b1100111: refImm = {{52{w[31]}}, w[31:20]};
      7'b0100011: refImm = {{52{w[31]}}, w[31:25], w[11:7]};
      7'b1100011: refImm = {{51{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
      7'b0110111, 7'b0010111: refImm = {{32{w[31]}}, w[31:12], 12'd0};
      7'b1101111: refImm = {{43{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
      7'b1110011: refImm = w[14] ? {59'd0, w[19:15]} : 64'd0;
      default: refImm = 64'd0;
    endcase
  endfunction

  function automatic string tagFor(input logic [31:0] w);
    case (w[6:0])
      7'b0000011, 7'b0010011, 7'b1100111: tagFor = "R2";
      7'b0100011: tagFor = "R3";
      7'b1100011: tagFor = "R4";
      7'b0110111, 7'b0010111: tagFor = "R5";
      7'b1101111: tagFor = "R6";
      7'b1110011: tagFor = w[14] ? "R7" : "R8";
      default: tagFor = "R8";
    endcase
  endfunction

  // Drive after a rising edge, sample at the following falling edge.
  task automatic applyCheck(input string tag, input logic [31:0] w, input logic [63:0] expVal);
    @(posedge clk);
    #1 instrWord = w;
    @(negedge clk);
    checks += 2;
    if (imm64 !== expVal) begin
      fails++;
      $display("FAIL %s (64-bit, R9) instr=%h actual=%h expected=%h", tag, w, imm64, expVal);
    end
    if (imm32 !== expVal[31:0]) begin
      fails++;
      $display("FAIL %s (32-bit) instr=%h actual=%h expected=%h", tag, w, imm32, expVal[31:0]);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [6:0] opList [0:15];
    opList[0] = 7'b0000011;  opList[1] = 7'b0010011;  opList[2] = 7'b1100111;
    opList[3] = 7'b0100011;  opList[4] = 7'b1100011;  opList[5] = 7'b0110111;
    opList[6] = 7'b0010111;  opList[7] = 7'b1101111;  opList[8] = 7'b1110011;
    opList[9] = 7'b0110011;  opList[10] = 7'b0000000; opList[11] = 7'b1111111;
    opList[12] = 7'b0001111; opList[13] = 7'b0101111; opList[14] = 7'b1010011;
    opList[15] = 7'b1110011;
    void'($urandom(32'd20240611));

    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle word after reset: opcode 0 has no immediate.
    applyCheck("R8 reset", 32'h0000_0000, 64'd0);

    // Directed corners.
    applyCheck("R2", 32'hFFF0_0013, 64'hFFFF_FFFF_FFFF_FFFF);
    applyCheck("R1 jreg", 32'h8010_0067, 64'hFFFF_FFFF_FFFF_F801);
    applyCheck("R3", 32'h8000_0FA3, 64'hFFFF_FFFF_FFFF_F81F);
    applyCheck("R4 max", 32'h7E00_0FE3, 64'h0000_0000_0000_0FFE);
    applyCheck("R4 min", 32'h8000_0063, 64'hFFFF_FFFF_FFFF_F000);
    applyCheck("R4 bit11", 32'h0000_00E3, 64'h0000_0000_0000_0800);
    applyCheck("R5", 32'hFFFF_F0B7, 64'hFFFF_FFFF_FFFF_F000);
    applyCheck("R1 pcup", 32'h7FFF_F017, 64'h0000_0000_7FFF_F000);
    applyCheck("R6 sign", 32'h8000_006F, 64'hFFFF_FFFF_FFF0_0000);
    applyCheck("R6 bit11", 32'h0010_006F, 64'h0000_0000_0000_0800);
    applyCheck("R7", 32'h800F_F073, 64'h0000_0000_0000_001F);
    applyCheck("R8 sys", 32'hFFFF_8073, 64'd0);
    applyCheck("R8 regop", 32'hFFFF_FFB3, 64'd0);

    // Random words for every opcode class.
    for (int k = 0; k < 16; k++) begin
      for (int n = 0; n < 250; n++) begin
        logic [31:0] w;
        w = $urandom();
        w[6:0] = opList[k];
        applyCheck(tagFor(w), w, refImm(w));
      end
    end

    finishRun();
  end

endmodule